// File: doc/BRIEF.md
# Byte-Wide Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM that has 19 address lines, an 8-bit bidirectional data bus and three active-low strobes: chip select, output enable and write strobe. The host starts a single read or a single write with a one-cycle request carrying a write flag, an address and a write byte. The controller then plays out a strobe sequence whose every phase is a whole number of clock cycles. Each count is the ceiling of a nanosecond limit divided by the clock-period parameter `CLK_NS`. A second parameter, `GRADE`, picks the faster (0) or the slower (1) timing table. When the operation is finished the controller raises `rdy` for one clock. For a read, `rdata` holds the captured byte in that same clock.

The sequencer is a five-state machine:

- **IDLE**: chip select is high, so the memory is in standby. A request moves it to RD_ACCESS or to WR_SETUP.
- **RD_ACCESS**: chip select and output enable are low. When its timer expires, the bus is captured and the machine returns to IDLE.
- **WR_SETUP**: chip select is low while both other strobes stay high. This gives a bus-release gap. On expiry it moves to WR_STROBE.
- **WR_STROBE**: the write strobe is low and the write byte is driven. On expiry it moves to WR_RECOVER.
- **WR_RECOVER**: all strobes are high and the byte is still driven. On expiry it returns to IDLE with `rdy`.

The address register loads only on the IDLE-to-busy transition. Output enable is low only in RD_ACCESS. At the default 8 ns period and fast grade the counts are: access 7, release gap 3, strobe 6, recovery 1.

Top module: `sram_ctl`

## Requirements
- R1: While `rst_n` is low, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1 and `rdy` is 0.
- R2: Outside an operation `mem_ce_n` is 1. A request is taken only on a clock edge where the controller is idle. A request raised while an operation is in progress has no effect on the strobes, the address or the memory contents.
- R3: A read drives `mem_ce_n`=0 and `mem_oe_n`=0 (with `mem_we_n`=1) for N_ACC cycles, where N_ACC is the ceiling of the largest of the address-access time, output-enable-access time and cycle time (55/25/55 ns fast grade, 70/35/70 ns slow) over `CLK_NS`. `rdata` then holds the bus value sampled at the edge that ends the access.
- R4: A write holds the write strobe low (chip select low, output enable high) for N_WP cycles. N_WP is the ceiling of the larger of the pulse width and the data setup (45/25 ns fast, 60/30 ns slow). This is followed by N_REC cycles with all strobes high. N_REC is the cycle time less the setup and strobe phases, with a minimum of 1.
- R5: `mem_addr` takes the request address at the acceptance edge and changes at no other time. It therefore never changes while chip select is low.
- R6: Output enable is high for the whole of a write. The controller drives `mem_dq` only while output enable is high. Driving starts only after output enable has been high for at least N_HZ cycles, where N_HZ is the ceiling of the release time (20 ns fast, 25 ns slow); WR_SETUP lasts N_HZ cycles.
- R7: `rdy` is a single-cycle pulse asserted while chip select is high. A new request may be accepted in that same cycle, which gives back-to-back operations.
- R8: The write strobe is low only while chip select is low. The write byte is driven unchanged on `mem_dq` through the strobe and recovery phases, so the memory stores exactly the requested byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, period `CLK_NS` |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start an operation (taken only when idle) |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address of the operation |
| req_wdata | input | 8 | Byte to write |
| rdy | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Byte captured by the last read |
| mem_addr | output | 19 | Address lines to the memory |
| mem_dq | inout | 8 | Bidirectional memory data bus |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |

## Verification
The properties assume three things. First, the clock really has the period given by `CLK_NS`. Second, the memory drives the bus only when chip select and output enable are low and the write strobe is high. Third, the host gives request fields that are steady during the cycle before an edge. The stimulus keeps to these assumptions with a 125 MHz clock matched to `CLK_NS`=8 and a zero-delay memory model that follows that decode. Requests are changed only at falling edges. On purpose, the stimulus holds requests high during busy periods so that the ignore rule is exercised.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_RD_ACCESS  = 3'd1,
        ST_WR_SETUP   = 3'd2,
        ST_WR_STROBE  = 3'd3,
        ST_WR_RECOVER = 3'd4
    } ctl_state_e;

    localparam int GRADE_FAST = 0;
    localparam int GRADE_SLOW = 1;

    function automatic int ceil_cycles(input int ns, input int period);
        return (ns + period - 1) / period;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Address stable to data valid
    function automatic int t_addr_access(input int grade);
        return (grade == GRADE_FAST) ? 55 : 70;
    endfunction

    // Output enable low to data valid
    function automatic int t_oe_access(input int grade);
        return (grade == GRADE_FAST) ? 25 : 35;
    endfunction

    // Minimum write strobe width, also address-to-strobe-rise
    function automatic int t_strobe_width(input int grade);
        return (grade == GRADE_FAST) ? 45 : 60;
    endfunction

    // Data stable before the terminating strobe edge
    function automatic int t_data_setup(input int grade);
        return (grade == GRADE_FAST) ? 25 : 30;
    endfunction

    // Minimum read or write cycle
    function automatic int t_cycle(input int grade);
        return (grade == GRADE_FAST) ? 55 : 70;
    endfunction

    // Strobe release to memory outputs at high impedance
    function automatic int t_release(input int grade);
        return (grade == GRADE_FAST) ? 20 : 25;
    endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
module sram_ctl_timer #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CW    = 3,
    parameter int N_ACC = 7,
    parameter int N_HZ  = 3,
    parameter int N_WP  = 6,
    parameter int N_REC = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic          expired,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          accept,
    output logic          capture,
    output logic          wr_done,
    output logic          ce_n,
    output logic          oe_n,
    output logic          we_n,
    output logic          drive
);

    ctl_state_e state_q, state_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions and phase timer loads
    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        load_val = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        wr_done  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req) begin
                    accept = 1'b1;
                    load   = 1'b1;
                    if (req_we) begin
                        state_d  = ST_WR_SETUP;
                        load_val = CW'(N_HZ - 1);
                    end else begin
                        state_d  = ST_RD_ACCESS;
                        load_val = CW'(N_ACC - 1);
                    end
                end
            end
            ST_RD_ACCESS: begin
                if (expired) begin
                    capture = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            ST_WR_SETUP: begin
                if (expired) begin
                    load     = 1'b1;
                    load_val = CW'(N_WP - 1);
                    state_d  = ST_WR_STROBE;
                end
            end
            ST_WR_STROBE: begin
                if (expired) begin
                    load     = 1'b1;
                    load_val = CW'(N_REC - 1);
                    state_d  = ST_WR_RECOVER;
                end
            end
            ST_WR_RECOVER: begin
                if (expired) begin
                    wr_done = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Registered strobes decoded from the next state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            drive <= 1'b0;
        end else begin
            ce_n  <= !((state_d == ST_RD_ACCESS) || (state_d == ST_WR_SETUP) ||
                       (state_d == ST_WR_STROBE));
            oe_n  <= (state_d != ST_RD_ACCESS);
            we_n  <= (state_d != ST_WR_STROBE);
            drive <= (state_d == ST_WR_STROBE) || (state_d == ST_WR_RECOVER);
        end
    end

endmodule

// File: rtl/sram_ctl_bus.sv
module sram_ctl_bus #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          capture,
    input  logic          wr_done,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] dq_in,
    output logic [AW-1:0] addr,
    output logic [DW-1:0] wbyte,
    output logic [DW-1:0] rbyte,
    output logic          rdy
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr  <= '0;
            wbyte <= '0;
            rbyte <= '0;
            rdy   <= 1'b0;
        end else begin
            rdy <= capture | wr_done;
            if (accept) begin
                addr  <= req_addr;
                wbyte <= req_wdata;
            end
            if (capture) begin
                rbyte <= dq_in;
            end
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int CLK_NS = 8,
    parameter int GRADE  = GRADE_FAST,
    parameter int AW     = 19,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          req_we,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          rdy,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    inout  wire  [DW-1:0] mem_dq,
    output logic          mem_ce_n,
    output logic          mem_oe_n,
    output logic          mem_we_n
);

    localparam int C_AA  = ceil_cycles(t_addr_access(GRADE), CLK_NS);
    localparam int C_OE  = ceil_cycles(t_oe_access(GRADE), CLK_NS);
    localparam int C_RC  = ceil_cycles(t_cycle(GRADE), CLK_NS);
    localparam int C_WP  = ceil_cycles(t_strobe_width(GRADE), CLK_NS);
    localparam int C_DS  = ceil_cycles(t_data_setup(GRADE), CLK_NS);
    localparam int C_HZ  = ceil_cycles(t_release(GRADE), CLK_NS);
    localparam int N_ACC = max2(max2(C_AA, C_OE), max2(C_RC, 1));
    localparam int N_HZ  = max2(1, C_HZ);
    localparam int N_WP  = max2(1, max2(C_WP, C_DS));
    localparam int N_REC = max2(1, C_RC - N_HZ - N_WP);
    localparam int N_MAX = max2(max2(N_ACC, N_HZ), max2(N_WP, N_REC));
    localparam int CW    = $clog2(N_MAX + 1);

    logic          load;
    logic [CW-1:0] load_val;
    logic          expired;
    logic          accept;
    logic          capture;
    logic          wr_done;
    logic          dq_drive;
    logic [DW-1:0] dq_wbyte;

    sram_ctl_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .expired  (expired)
    );

    sram_ctl_fsm #(
        .CW    (CW),
        .N_ACC (N_ACC),
        .N_HZ  (N_HZ),
        .N_WP  (N_WP),
        .N_REC (N_REC)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (req),
        .req_we   (req_we),
        .expired  (expired),
        .load     (load),
        .load_val (load_val),
        .accept   (accept),
        .capture  (capture),
        .wr_done  (wr_done),
        .ce_n     (mem_ce_n),
        .oe_n     (mem_oe_n),
        .we_n     (mem_we_n),
        .drive    (dq_drive)
    );

    sram_ctl_bus #(.AW(AW), .DW(DW)) u_bus (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .wr_done   (wr_done),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .dq_in     (mem_dq),
        .addr      (mem_addr),
        .wbyte     (dq_wbyte),
        .rbyte     (rdata),
        .rdy       (rdy)
    );

    assign mem_dq = dq_drive ? dq_wbyte : {DW{1'bz}};

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
    parameter int AW   = 19,
    parameter int DW   = 8,
    parameter int N_HZ = 3,
    parameter int N_WP = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rdy,
    input logic          ce_n,
    input logic          oe_n,
    input logic          we_n,
    input logic [AW-1:0] addr,
    input logic          drive,
    input logic [DW-1:0] wbyte
);

    logic [7:0] oe_hi_cnt;
    logic [7:0] we_lo_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oe_hi_cnt <= '0;
            we_lo_cnt <= '0;
        end else begin
            oe_hi_cnt <= !oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
            we_lo_cnt <= we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
        end
    end

    // R8: write strobe only under chip select
    p_we_under_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !ce_n);

    // R6: output enable stays high during a write strobe
    p_oe_high_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> oe_n);

    // R6: never drive while the memory may be driving
    p_no_drive_oe_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        drive |-> oe_n);

    // R6: release gap before the controller starts driving
    p_turnaround_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive) |-> (oe_hi_cnt >= 8'(N_HZ)));

    // R5: address frozen while chip select is low
    p_addr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && $past(!ce_n)) |-> $stable(addr));

    // R4: strobe width in cycles
    p_pulse_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we_n) |-> (we_lo_cnt >= 8'(N_WP)));

    // R8: driven byte steady for the whole drive window
    p_wdata_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (drive && $past(drive)) |-> $stable(wbyte));

    // R7: ready is a single-cycle pulse
    p_rdy_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

    // R7: ready only while deselected
    p_rdy_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |-> ce_n);

endmodule

bind sram_ctl sram_ctl_chk #(
    .AW   (AW),
    .DW   (DW),
    .N_HZ (N_HZ),
    .N_WP (N_WP)
) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .rdy   (rdy),
    .ce_n  (mem_ce_n),
    .oe_n  (mem_oe_n),
    .we_n  (mem_we_n),
    .addr  (mem_addr),
    .drive (dq_drive),
    .wbyte (dq_wbyte)
);

// File: tb/sim_sram_ctl.sv
module sim_sram_ctl;

    localparam int PER   = 8;
    localparam int E_ACC = (55 + PER - 1) / PER;
    localparam int E_HZ  = (20 + PER - 1) / PER;
    localparam int E_WP  = (45 + PER - 1) / PER;
    localparam int E_RC  = (55 + PER - 1) / PER;
    localparam int E_REC = (E_RC - E_HZ - E_WP < 1) ? 1 : (E_RC - E_HZ - E_WP);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0;
    logic        req_we = 1'b0;
    logic [18:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    wire         rdy;
    wire  [7:0]  rdata;
    wire  [18:0] mem_addr;
    wire  [7:0]  mem_dq;
    wire         mem_ce_n;
    wire         mem_oe_n;
    wire         mem_we_n;

    always #4 clk = ~clk;

    sram_ctl #(.CLK_NS(PER), .GRADE(0)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rdy       (rdy),
        .rdata     (rdata),
        .mem_addr  (mem_addr),
        .mem_dq    (mem_dq),
        .mem_ce_n  (mem_ce_n),
        .mem_oe_n  (mem_oe_n),
        .mem_we_n  (mem_we_n)
    );

    // Zero-delay memory model, 256 locations on the low address byte
    logic [7:0] sram_mem [256];
    logic [7:0] exp_mem  [256];
    wire sram_drv = !mem_ce_n && !mem_oe_n && mem_we_n;
    assign mem_dq = sram_drv ? sram_mem[mem_addr[7:0]] : 8'bz;

    typedef struct {
        bit         ce_n;
        bit         oe_n;
        bit         we_n;
        bit         rdy;
        bit         chk_dq;
        bit         chk_rd;
        logic [7:0] val;
        string      tag;
    } cyc_t;

    cyc_t        exq[$];
    int          errors = 0;
    int          checks = 0;
    bit          finished = 0;
    logic [18:0] exp_addr = '0;
    bit          wr_pend = 0;
    logic [7:0]  wr_a;
    logic [7:0]  wr_d;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic cyc_t mk(input bit ce, input bit oe, input bit we, input bit r,
                                input bit cdq, input bit crd, input logic [7:0] v,
                                input string t);
        cyc_t e;
        e.ce_n = ce; e.oe_n = oe; e.we_n = we; e.rdy = r;
        e.chk_dq = cdq; e.chk_rd = crd; e.val = v; e.tag = t;
        return e;
    endfunction

    task automatic cycle(input bit r, input bit w, input logic [18:0] a,
                         input logic [7:0] d, output bit taken);
        cyc_t e;
        bit   idle;
        @(negedge clk);
        if (exq.size() == 0) e = mk(1, 1, 1, 0, 0, 0, 8'h00, "R2");
        else                 e = exq.pop_front();
        idle = e.ce_n && !e.chk_dq;
        chk(mem_ce_n == e.ce_n, e.tag, "ce_n", 32'(mem_ce_n), 32'(e.ce_n));
        chk(mem_oe_n == e.oe_n, e.tag, "oe_n", 32'(mem_oe_n), 32'(e.oe_n));
        chk(mem_we_n == e.we_n, e.tag, "we_n", 32'(mem_we_n), 32'(e.we_n));
        chk(rdy == e.rdy, "R7", "rdy", 32'(rdy), 32'(e.rdy));
        chk(mem_addr == exp_addr, "R5", "addr", 32'(mem_addr), 32'(exp_addr));
        if (e.chk_dq) chk(mem_dq == e.val, "R8", "dq", 32'(mem_dq), 32'(e.val));
        if (e.chk_rd) chk(rdata == e.val, "R3", "rdata", 32'(rdata), 32'(e.val));
        // memory model: latch during write, commit when the strobe ends
        if (!mem_ce_n && !mem_we_n) begin
            wr_pend = 1; wr_a = mem_addr[7:0]; wr_d = mem_dq;
        end else if (wr_pend) begin
            sram_mem[wr_a] = wr_d; wr_pend = 0;
        end
        req = r; req_we = w; req_addr = a; req_wdata = d;
        taken = r && idle;
        if (taken) begin
            exp_addr = a;
            if (w) begin
                for (int i = 0; i < E_HZ; i++)  exq.push_back(mk(0, 1, 1, 0, 0, 0, 8'h00, "R6"));
                for (int i = 0; i < E_WP; i++)  exq.push_back(mk(0, 1, 0, 0, 1, 0, d, "R4"));
                for (int i = 0; i < E_REC; i++) exq.push_back(mk(1, 1, 1, 0, 1, 0, d, "R4"));
                exq.push_back(mk(1, 1, 1, 1, 0, 0, 8'h00, "R7"));
                exp_mem[a[7:0]] = d;
            end else begin
                for (int i = 0; i < E_ACC; i++) exq.push_back(mk(0, 0, 1, 0, 0, 0, 8'h00, "R3"));
                exq.push_back(mk(1, 1, 1, 1, 0, 1, exp_mem[a[7:0]], "R7"));
            end
        end
    endtask

    task automatic op(input bit w, input logic [18:0] a, input logic [7:0] d);
        bit tk;
        tk = 0;
        while (!tk) cycle(1, w, a, d, tk);
    endtask

    initial begin
        bit tk;
        for (int i = 0; i < 256; i++) begin
            sram_mem[i] = 8'(i * 7 + 3);
            exp_mem[i]  = 8'(i * 7 + 3);
        end
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            chk(mem_ce_n == 1'b1, "R1", "ce_n", 32'(mem_ce_n), 32'd1);
            chk(mem_oe_n == 1'b1, "R1", "oe_n", 32'(mem_oe_n), 32'd1);
            chk(mem_we_n == 1'b1, "R1", "we_n", 32'(mem_we_n), 32'd1);
            chk(rdy == 1'b0, "R1", "rdy", 32'(rdy), 32'd0);
        end
        rst_n = 1'b1;
        // R2: idle keeps the memory deselected
        repeat (3) cycle(0, 0, '0, '0, tk);
        // R4, R8: writes; R7 back-to-back via held request
        op(1, 19'h00012, 8'h5A);
        op(1, 19'h7FF34, 8'hA5);
        // R3: reads of written and unwritten locations
        op(0, 19'h00012, 8'h00);
        op(0, 19'h7FF34, 8'h00);
        op(0, 19'h00056, 8'h00);
        // top address, all-ones data, write then read back
        op(1, 19'h7FFFF, 8'hFF);
        op(0, 19'h7FFFF, 8'h00);
        // R2: a request while busy is ignored
        op(1, 19'h00099, 8'h11);
        cycle(1, 1, 19'h00078, 8'hEE, tk);
        cycle(0, 0, '0, '0, tk);
        op(0, 19'h00078, 8'h00);
        op(0, 19'h00099, 8'h00);
        // all-zero data write and read
        op(1, 19'h00000, 8'h00);
        op(0, 19'h00000, 8'h00);
        while (exq.size() > 0) cycle(0, 0, '0, '0, tk);
        repeat (3) cycle(0, 0, '0, '0, tk);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(PER * 200000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL R2 watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule